// File: doc/BRIEF.md
# Gate Listen-Mode Wake Detector

This block sits beside the gate driver of a primary-side flyback controller. It keeps the switch under control when the load is so light that pulses are far apart. When no switching request has been seen for a programmable number of clock cycles, it disables the driver so that the gate pin floats. While the pin floats it is used as an input. A comparator on the pin reports edges. The secondary side can inject a short ring onto that pin to ask for attention.

Such an edge is taken as a wake event once a short blanking window has passed. The block then enables the driver and issues a single forced turn-on pulse, so that a fresh output-voltage sample becomes available. Only the first sample after a wake can start a frequency boost, and only if that sample lies below the lower threshold. The boost ends when any sample reaches the upper threshold. The gap between the two thresholds gives the boost its hysteresis.

Top module: `gate_listen_wake`

## Requirements
- R1: After reset, or after any cycle in which `gate_req` is sampled high, `drv_en` falls to 0 right after the IDLE_CYC-th consecutive clock edge that samples `gate_req` low. While the driver is enabled, a high `gate_req` restarts this count.
- R2: While `drv_en` is 0 and the blanking window of R5 has expired, a `pin_edge` sampled high is a wake event. On the next cycle `drv_en`, `gate_out` and `force_on` are all 1. A `pin_edge` sampled while `drv_en` is 1 never produces `force_on`.
- R3: While the driver is enabled, `gate_out` equals `gate_req` delayed by one cycle. A request that arrives while the pin floats first sets `drv_en` to 1 with `gate_out` at 0, and `gate_out` rises one cycle later. `gate_out` is never 1 while `drv_en` is 0.
- R4: `force_on` lasts exactly one cycle. A wake returns the block to driving and restarts the idle count, so each listening interval accepts at most one wake.
- R5: For BLANK_CYC clock edges after any change of `drv_en`, `pin_edge` is ignored. The first edge that can be accepted is the (BLANK_CYC+1)-th edge of a listening interval.
- R6: Define the wake sample as the first cycle with `samp_valid` high after a wake event. If that cycle has `samp_below_en`=1 and `samp_at_dis`=0, `boost` is 1 from the next cycle.
- R7: A sample with `samp_below_en`=1 that is not a wake sample leaves `boost` unchanged.
- R8: A sample with `samp_at_dis`=1 clears `boost` on the next cycle, and this takes priority over R6. A sample with both comparator bits at 0 leaves `boost` unchanged.
- R9: During and right after reset: `drv_en`=1, `gate_out`=0, `force_on`=0, `boost`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gate_req | input | 1 | Switching request from the PWM logic |
| pin_edge | input | 1 | Gate-pin edge comparator output, already synchronized |
| samp_valid | input | 1 | An output-voltage sample is ready this cycle |
| samp_below_en | input | 1 | The sample lies below the boost-enable threshold |
| samp_at_dis | input | 1 | The sample is at or above the boost-disable threshold |
| drv_en | output | 1 | Driver enable; 0 lets the gate pin float |
| gate_out | output | 1 | Gate drive level |
| force_on | output | 1 | One-cycle forced turn-on marker on a wake |
| boost | output | 1 | Raised switching frequency requested |

## Verification
The bench targets the exact cycle of the idle timeout, one cycle early and on time. A design that is off by one would float the pin one cycle too soon or too late. It holds `pin_edge` high across the whole blanking window after the pin is released. A design with a short or missing blank would wake on its own release transient. It checks that a sample below the lower threshold that does not follow a wake leaves the boost off, that a sample between the thresholds keeps the boost on, and that a second edge right after a wake produces no second pulse. Each of these faults shows up as a wrong flag or as a repeated `force_on`. Random phases with sparse requests run a cycle-accurate model alongside, which catches gate drive reaching the pin while the driver is released.

// File: rtl/glw_pkg.sv
`timescale 1ns/1ps
package glw_pkg;

    typedef enum logic {
        GLW_DRIVE  = 1'b0,
        GLW_LISTEN = 1'b1
    } glw_mode_e;

    typedef struct packed {
        logic valid;
        logic below_en;
        logic at_dis;
    } glw_sample_t;

    // Next boost state: a sample at the upper threshold clears first; only a
    // sample taken right after a wake may set it.
    function automatic logic glw_boost_next(input logic cur, input logic pend,
                                            input glw_sample_t s);
        logic nxt;
        nxt = cur;
        if (s.valid && s.at_dis)
            nxt = 1'b0;
        else if (s.valid && pend && s.below_en)
            nxt = 1'b1;
        return nxt;
    endfunction

    function automatic int glw_width(input int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/glw_idle_timer.sv
`timescale 1ns/1ps
module glw_idle_timer #(
    parameter int IDLE_CYC = 25000
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    output logic expire
);
    import glw_pkg::*;

    localparam int CW = glw_width(IDLE_CYC);
    localparam logic [CW-1:0] LAST = CW'(IDLE_CYC - 1);

    logic [CW-1:0] cnt_q;

    assign expire = (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (restart)
            cnt_q <= '0;
        else if (!expire)
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/glw_listen_fsm.sv
`timescale 1ns/1ps
module glw_listen_fsm #(
    parameter int BLANK_CYC = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  gate_req,
    input  logic                  pin_edge,
    input  logic                  expire,
    output glw_pkg::glw_mode_e    mode,
    output logic                  wake,
    output logic                  gate_out,
    output logic                  force_on
);
    import glw_pkg::*;

    localparam int BW = glw_width(BLANK_CYC + 1);
    localparam logic [BW-1:0] BLANK_LOAD = BW'(BLANK_CYC);

    glw_mode_e     mode_q, mode_d;
    logic [BW-1:0] blank_q;
    logic          gate_q, force_q;
    logic          listening;

    assign listening = (mode_q == GLW_LISTEN);
    assign wake      = listening && (blank_q == '0) && pin_edge;

    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            GLW_DRIVE:  if (!gate_req && expire) mode_d = GLW_LISTEN;
            GLW_LISTEN: if (wake || gate_req)    mode_d = GLW_DRIVE;
            default:    mode_d = GLW_DRIVE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= GLW_DRIVE;
            blank_q <= '0;
            gate_q  <= 1'b0;
            force_q <= 1'b0;
        end else begin
            mode_q  <= mode_d;
            if (mode_d != mode_q)
                blank_q <= BLANK_LOAD;
            else if (blank_q != '0)
                blank_q <= blank_q - 1'b1;
            // Normal drive only when the driver was already enabled this cycle.
            gate_q  <= wake || (gate_req && !listening);
            force_q <= wake;
        end
    end

    assign mode     = mode_q;
    assign gate_out = gate_q;
    assign force_on = force_q;
endmodule

// File: rtl/glw_boost_qual.sv
`timescale 1ns/1ps
module glw_boost_qual (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wake,
    input  glw_pkg::glw_sample_t samp,
    output logic                 boost
);
    import glw_pkg::*;

    logic pend_q, boost_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q  <= 1'b0;
            boost_q <= 1'b0;
        end else begin
            boost_q <= glw_boost_next(boost_q, pend_q, samp);
            if (wake)
                pend_q <= 1'b1;
            else if (samp.valid)
                pend_q <= 1'b0;
        end
    end

    assign boost = boost_q;
endmodule

// File: rtl/gate_listen_wake.sv
`timescale 1ns/1ps
module gate_listen_wake #(
    parameter int IDLE_CYC  = 25000,
    parameter int BLANK_CYC = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic gate_req,
    input  logic pin_edge,
    input  logic samp_valid,
    input  logic samp_below_en,
    input  logic samp_at_dis,
    output logic drv_en,
    output logic gate_out,
    output logic force_on,
    output logic boost
);
    import glw_pkg::*;

    glw_mode_e   mode;
    glw_sample_t samp;
    logic        expire, wake;

    assign samp = '{valid: samp_valid, below_en: samp_below_en, at_dis: samp_at_dis};

    glw_idle_timer #(.IDLE_CYC(IDLE_CYC)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .restart (gate_req | wake),
        .expire  (expire)
    );

    glw_listen_fsm #(.BLANK_CYC(BLANK_CYC)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .gate_req (gate_req),
        .pin_edge (pin_edge),
        .expire   (expire),
        .mode     (mode),
        .wake     (wake),
        .gate_out (gate_out),
        .force_on (force_on)
    );

    glw_boost_qual u_boost (
        .clk   (clk),
        .rst   (rst),
        .wake  (wake),
        .samp  (samp),
        .boost (boost)
    );

    assign drv_en = (mode == GLW_DRIVE);
endmodule

// File: rtl/glw_checker.sv
`timescale 1ns/1ps
module glw_checker (
    input logic clk,
    input logic rst,
    input logic pin_edge,
    input logic samp_valid,
    input logic samp_below_en,
    input logic samp_at_dis,
    input logic drv_en,
    input logic gate_out,
    input logic force_on,
    input logic boost
);
    AST_GATE_NEEDS_DRV: assert property (@(posedge clk) disable iff (rst)
        gate_out |-> drv_en); // R3
    AST_EDGE_WHILE_DRIVING: assert property (@(posedge clk) disable iff (rst)
        (drv_en && pin_edge) |=> !force_on); // R2
    AST_FORCE_FROM_LISTEN: assert property (@(posedge clk) disable iff (rst)
        force_on |-> (gate_out && drv_en && $past(!drv_en))); // R2
    AST_FORCE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        force_on |=> !force_on); // R4
    AST_BOOST_SET_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(boost) |-> $past(samp_valid && samp_below_en && !samp_at_dis)); // R6
    AST_BOOST_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (samp_valid && samp_at_dis) |=> !boost); // R8
endmodule

bind gate_listen_wake glw_checker u_glw_checker (
    .clk           (clk),
    .rst           (rst),
    .pin_edge      (pin_edge),
    .samp_valid    (samp_valid),
    .samp_below_en (samp_below_en),
    .samp_at_dis   (samp_at_dis),
    .drv_en        (drv_en),
    .gate_out      (gate_out),
    .force_on      (force_on),
    .boost         (boost)
);

// File: tb/gate_listen_wake_tb_top.sv
`timescale 1ns/1ps
module gate_listen_wake_tb_top;
    localparam int IDLE  = 40;
    localparam int BLANK = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic gate_req = 1'b0, pin_edge = 1'b0;
    logic samp_valid = 1'b0, samp_below_en = 1'b0, samp_at_dis = 1'b0;
    logic drv_en, gate_out, force_on, boost;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    gate_listen_wake #(.IDLE_CYC(IDLE), .BLANK_CYC(BLANK)) dut_i (
        .clk(clk), .rst(rst), .gate_req(gate_req), .pin_edge(pin_edge),
        .samp_valid(samp_valid), .samp_below_en(samp_below_en),
        .samp_at_dis(samp_at_dis), .drv_en(drv_en), .gate_out(gate_out),
        .force_on(force_on), .boost(boost)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model built from the requirements.
    bit m_listen, m_gate, m_force, m_pend, m_boost, m_wake, m_nl;
    int m_cnt, m_blank;
    always @(posedge clk) begin
        if (rst) begin
            m_listen = 0; m_gate = 0; m_force = 0; m_pend = 0; m_boost = 0;
            m_cnt = 0; m_blank = 0;
        end else begin
            m_wake = m_listen && (m_blank == 0) && pin_edge;
            if (samp_valid && samp_at_dis) m_boost = 0;
            else if (samp_valid && m_pend && samp_below_en) m_boost = 1;
            if (m_wake) m_pend = 1; else if (samp_valid) m_pend = 0;
            m_gate  = m_wake || (gate_req && !m_listen);
            m_force = m_wake;
            m_nl = m_listen ? !(m_wake || gate_req) : (!gate_req && m_cnt == IDLE - 1);
            if (m_nl != m_listen) m_blank = BLANK;
            else if (m_blank > 0) m_blank--;
            m_listen = m_nl;
            if (gate_req || m_wake) m_cnt = 0;
            else if (m_cnt < IDLE - 1) m_cnt++;
        end
    end

    always @(posedge clk) begin
        #1;
        if (!rst) begin
            check("R1 model drv_en", drv_en, !m_listen);
            check("R3 model gate_out", gate_out, m_gate);
            check("R2 model force_on", force_on, m_force);
            check("R6 model boost", boost, m_boost);
        end
    end

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #(4 * 200000);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R9 reset drv_en", drv_en, 1'b1);
        check("R9 reset gate_out", gate_out, 1'b0);
        check("R9 reset force_on", force_on, 1'b0);
        check("R9 reset boost", boost, 1'b0);
        repeat (IDLE - 1) @(negedge clk);
        check("R1 one cycle before timeout", drv_en, 1'b1);
        @(negedge clk);
        check("R1 timeout releases driver", drv_en, 1'b0);
        pin_edge = 1'b1;
        repeat (BLANK) @(negedge clk);
        check("R5 edge in blank ignored force", force_on, 1'b0);
        check("R5 edge in blank ignored drv", drv_en, 1'b0);
        @(negedge clk);
        check("R2 wake force_on", force_on, 1'b1);
        check("R2 wake gate_out", gate_out, 1'b1);
        check("R2 wake drv_en", drv_en, 1'b1);
        @(negedge clk);
        check("R4 single force pulse", force_on, 1'b0);
        pin_edge = 1'b0;
        samp_valid = 1'b1; samp_below_en = 1'b1;
        @(negedge clk);
        check("R6 wake sample low sets boost", boost, 1'b1);
        samp_below_en = 1'b0;
        @(negedge clk);
        check("R8 mid sample keeps boost", boost, 1'b1);
        samp_at_dis = 1'b1;
        @(negedge clk);
        check("R8 high sample clears boost", boost, 1'b0);
        samp_at_dis = 1'b0; samp_below_en = 1'b1;
        @(negedge clk);
        check("R7 non-wake low sample ignored", boost, 1'b0);
        samp_valid = 1'b0; samp_below_en = 1'b0;
        gate_req = 1'b1;
        @(negedge clk);
        gate_req = 1'b0;
        repeat (IDLE) @(negedge clk);
        check("R1 second timeout", drv_en, 1'b0);
        gate_req = 1'b1;
        @(negedge clk);
        check("R3 request re-enables driver", drv_en, 1'b1);
        check("R3 gate low on first driven cycle", gate_out, 1'b0);
        @(negedge clk);
        check("R3 gate follows request", gate_out, 1'b1);
        pin_edge = 1'b1;
        repeat (3) @(negedge clk);
        check("R2 edge while driving ignored", force_on, 1'b0);
        pin_edge = 1'b0; gate_req = 1'b0;

        void'($urandom(32'h5eed_1234));
        for (int ph = 0; ph < 40; ph++) begin
            int req_pct;
            req_pct = (ph % 3 == 0) ? 20 : ((ph % 3 == 1) ? 1 : 0);
            for (int c = 0; c < 150; c++) begin
                int lvl;
                @(negedge clk);
                gate_req   = ($urandom % 100) < req_pct;
                pin_edge   = ($urandom % 100) < 6;
                samp_valid = ($urandom % 100) < 15;
                lvl = $urandom % 3;
                samp_below_en = (lvl == 0);
                samp_at_dis   = (lvl == 2);
            end
        end
        @(negedge clk);
        finish_run();
    end
endmodule